// File: doc/BRIEF.md
# Program Status Register Access Unit

This unit owns the processor's current status word and a set of saved status words, one kept separately for each exception mode. It carries out the two status-transfer operations that an instruction pipeline issues. A read copies a whole status word onto the read-data output, so that it can be written to a general register. A write updates a status word from register data, or from an 8-bit immediate rotated into a 32-bit word. A write may replace the full word or only the four condition flags N, Z, C and V.

The current mode, held in bits [4:0] of the current status word, decides which saved word is visible and how much of the current word may change. Mode encodings are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. User and system modes have no saved word. An operation that names register 15 as its source or destination is reported as invalid and changes nothing.

Top module: `psr_access_unit`

## Requirements
- R1: After reset the current status word is 0x000000D3: supervisor mode, bits [7:6] set, all flags clear. Every saved word is zero.
- R2: A flags-only write copies bits [31:28] of the source into bits [31:28] of the target (N, Z, C, V from bit 31 down) and keeps the target's bits [27:0].
- R3: An immediate source is the low 8 bits of the 12-bit field rotated right by twice the field's upper 4 bits. An immediate write is always treated as flags-only, so only the top four bits of the rotated value are used.
- R4: In user mode a full-word write to the current word changes only bits [31:28].
- R5: In any privileged mode a full-word write to the current word replaces all 32 bits.
- R6: In fast interrupt, interrupt, supervisor, abort and undefined modes, saved-word accesses reach the word banked for that mode only, and both full-word and flags-only writes are applied to it.
- R7: A valid read drives all 32 bits of the selected word, current or saved, onto rdData, unchanged.
- R8: In user or system mode a saved-word write has no effect and a saved-word read returns zero.
- R9: An operation whose register number is 15 (any read, or any write from a register) raises opInvalid, updates nothing and reads zero. A write from an immediate uses no register and is never invalid.
- R10: With opValid low or condPass low nothing is updated, opInvalid stays low and rdData is zero.
- R11: A write takes effect at the next rising clock edge. rdData is combinational from the registered state and the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| condPass | input | 1 | The operation's condition passed |
| isWrite | input | 1 | 1 = write a status word, 0 = read one |
| targetSaved | input | 1 | 1 = saved word of the current mode, 0 = current word |
| flagsOnly | input | 1 | Write only bits [31:28] |
| useImm | input | 1 | Write source is the rotated immediate rather than regData |
| regIdx | input | 4 | Source or destination register number |
| regData | input | 32 | Register source operand |
| immField | input | 12 | Rotate amount [11:8] and 8-bit value [7:0] |
| rdData | output | 32 | Read result, zero when no valid read |
| curPsr | output | 32 | Live current status word |
| opInvalid | output | 1 | The presented operation names register 15 |

## Verification
The bench moves through supervisor, interrupt, system and user modes so that a bank selected by a wrong index, a saved word shared across modes, or a saved access left open in system mode each shows up as a read that returns another mode's value or a non-zero word. It writes immediates with non-zero rotate amounts, with and without the flags-only select; a rotation off by a factor of two, or an immediate that is allowed to fill the whole word, leaves the wrong flags or corrupts the mode bits. In user mode it issues full-word writes whose low bits would drop the unit out of user mode if they were applied. It also sends register 15 operations and operations whose condition failed, where any leak would show as a changed status word or a non-zero read.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DATA_W     = 32;
  localparam int FLAG_W     = 4;
  localparam int NUM_BANKS  = 5;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int MODE_W     = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [DATA_W-1:0] PSR_RESET = 32'h0000_00D3;

  // strobes from control to datapath
  typedef struct packed {
    logic                  wrCur;
    logic                  wrSaved;
    logic                  flagsOnly;
    logic                  selImm;
    logic                  rdCur;
    logic                  rdSaved;
    logic [BANK_IDX_W-1:0] bankIdx;
  } psr_ctrl_t;
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic              opValid,
  input  logic              condPass,
  input  logic              isWrite,
  input  logic              targetSaved,
  input  logic              flagsOnly,
  input  logic              useImm,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [MODE_W-1:0] curMode,
  output psr_ctrl_t         ctrl,
  output logic              opInvalid
);
  localparam logic [REG_W-1:0] REG_ILLEGAL = {REG_W{1'b1}};

  logic                  fire;
  logic                  usesReg;
  logic                  go;
  logic                  bankHit;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  isUser;

  always_comb begin
    bankHit = 1'b1;
    bankIdx = '0;
    unique case (curMode)
      MODE_FIQ: bankIdx = BANK_IDX_W'(0);
      MODE_IRQ: bankIdx = BANK_IDX_W'(1);
      MODE_SVC: bankIdx = BANK_IDX_W'(2);
      MODE_ABT: bankIdx = BANK_IDX_W'(3);
      MODE_UND: bankIdx = BANK_IDX_W'(4);
      default:  bankHit = 1'b0;
    endcase
  end

  assign fire      = opValid && condPass;
  assign usesReg   = !(isWrite && useImm);
  assign opInvalid = fire && usesReg && (regIdx == REG_ILLEGAL);
  assign go        = fire && !opInvalid;
  assign isUser    = (curMode == MODE_USR);

  always_comb begin
    ctrl           = '0;
    ctrl.wrCur     = go && isWrite && !targetSaved;
    ctrl.wrSaved   = go && isWrite && targetSaved && bankHit;
    ctrl.flagsOnly = flagsOnly || useImm || (isUser && !targetSaved);
    ctrl.selImm    = useImm;
    ctrl.rdCur     = go && !isWrite && !targetSaved;
    ctrl.rdSaved   = go && !isWrite && targetSaved && bankHit;
    ctrl.bankIdx   = bankIdx;
  end
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
#(
  parameter int IMM_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  psr_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] regData,
  input  logic [IMM_W-1:0]  immField,
  output logic [DATA_W-1:0] curPsr,
  output logic [DATA_W-1:0] rdData
);
  localparam int VAL_W = 8;
  localparam int ROT_W = IMM_W - VAL_W;
  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]    rotAmt;
  logic [DATA_W-1:0]   immExt;
  logic [2*DATA_W-1:0] immDbl;
  logic [DATA_W-1:0]   srcWord;
  logic [DATA_W-1:0]   curNext;
  logic [DATA_W-1:0]   savedNext;
  logic [DATA_W-1:0]   bankView [NUM_BANKS];
  logic [DATA_W-1:0]   curQ;

  function automatic logic [DATA_W-1:0] mergeWord(
    input logic [DATA_W-1:0] oldW,
    input logic [DATA_W-1:0] newW,
    input logic              onlyFlags
  );
    if (onlyFlags)
      return {newW[DATA_W-1 -: FLAG_W], oldW[DATA_W-FLAG_W-1:0]};
    return newW;
  endfunction

  // rotate right by twice the upper field
  assign rotAmt  = {immField[IMM_W-1:VAL_W], 1'b0};
  assign immExt  = {{(DATA_W-VAL_W){1'b0}}, immField[VAL_W-1:0]};
  assign immDbl  = {immExt, immExt} >> rotAmt;
  assign srcWord = ctrl.selImm ? immDbl[DATA_W-1:0] : regData;

  assign curNext   = mergeWord(curQ, srcWord, ctrl.flagsOnly);
  assign savedNext = mergeWord(bankView[ctrl.bankIdx], srcWord, ctrl.flagsOnly);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           curQ <= PSR_RESET;
    else if (ctrl.wrCur) curQ <= curNext;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] savedQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        savedQ <= '0;
      else if (ctrl.wrSaved && (ctrl.bankIdx == BANK_IDX_W'(b)))
        savedQ <= savedNext;
    end
    assign bankView[b] = savedQ;
  end

  assign curPsr = curQ;

  always_comb begin
    if (ctrl.rdCur)        rdData = curQ;
    else if (ctrl.rdSaved) rdData = bankView[ctrl.bankIdx];
    else                   rdData = '0;
  end
endmodule

// File: rtl/psr_access_unit.sv
module psr_access_unit
  import psr_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int IMM_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              condPass,
  input  logic              isWrite,
  input  logic              targetSaved,
  input  logic              flagsOnly,
  input  logic              useImm,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] regData,
  input  logic [IMM_W-1:0]  immField,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] curPsr,
  output logic              opInvalid
);
  psr_ctrl_t ctrl;

  psr_ctrl #(.REG_W(REG_W)) u_ctrl (
    .opValid    (opValid),
    .condPass   (condPass),
    .isWrite    (isWrite),
    .targetSaved(targetSaved),
    .flagsOnly  (flagsOnly),
    .useImm     (useImm),
    .regIdx     (regIdx),
    .curMode    (curPsr[MODE_W-1:0]),
    .ctrl       (ctrl),
    .opInvalid  (opInvalid)
  );

  psr_datapath #(.IMM_W(IMM_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .regData (regData),
    .immField(immField),
    .curPsr  (curPsr),
    .rdData  (rdData)
  );
endmodule

// File: rtl/psr_access_sva.sv
module psr_access_sva
  import psr_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int IMM_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              condPass,
  input logic              isWrite,
  input logic              targetSaved,
  input logic              flagsOnly,
  input logic              useImm,
  input logic [REG_W-1:0]  regIdx,
  input logic [DATA_W-1:0] regData,
  input logic [IMM_W-1:0]  immField,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] curPsr,
  input logic              opInvalid
);
  p_user_low_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curPsr[MODE_W-1:0] == MODE_USR) |=> curPsr[DATA_W-FLAG_W-1:0] == $past(curPsr[DATA_W-FLAG_W-1:0]));

  p_flags_write_low_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && condPass && isWrite && !targetSaved && (flagsOnly || useImm))
      |=> curPsr[DATA_W-FLAG_W-1:0] == $past(curPsr[DATA_W-FLAG_W-1:0]));

  p_idle_no_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && condPass) |=> $stable(curPsr));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && condPass) |-> (rdData == '0) && !opInvalid);

  p_invalid_no_change_r9: assert property (@(posedge clk) disable iff (!rstN)
    opInvalid |=> $stable(curPsr));

  p_invalid_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    opInvalid |-> rdData == '0);

  p_saved_read_user_sys_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isWrite && targetSaved &&
     (curPsr[MODE_W-1:0] == MODE_USR || curPsr[MODE_W-1:0] == MODE_SYS)) |-> rdData == '0);
endmodule

bind psr_access_unit psr_access_sva #(.REG_W(REG_W), .IMM_W(IMM_W)) u_sva (.*);

// File: tb/tb_psr_access_unit.sv
module tb_psr_access_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 0, condPass = 0, isWrite = 0, targetSaved = 0;
  logic        flagsOnly = 0, useImm = 0;
  logic [3:0]  regIdx = '0;
  logic [31:0] regData = '0;
  logic [11:0] immField = '0;
  logic [31:0] rdData, curPsr;
  logic        opInvalid;

  int total = 0;
  int fails = 0;

  typedef struct {
    string       req;
    logic [31:0] expRd;
    logic        expInv;
    logic [31:0] expCur;
  } item_t;
  item_t sbq[$];

  logic [31:0] mCur;
  logic [31:0] mSaved [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_access_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .condPass(condPass),
    .isWrite(isWrite), .targetSaved(targetSaved), .flagsOnly(flagsOnly),
    .useImm(useImm), .regIdx(regIdx), .regData(regData), .immField(immField),
    .rdData(rdData), .curPsr(curPsr), .opInvalid(opInvalid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bankOf(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  // driver: applies one operation and pushes what the monitor must see
  task automatic doOp(input string req, input logic v, input logic c, input logic w,
                      input logic s, input logic f, input logic im,
                      input logic [3:0] r, input logic [31:0] d, input logic [11:0] imf);
    item_t it;
    logic fire, inv, flagsEff;
    logic [31:0] src, rot;
    logic [63:0] dbl;
    int b;
    @(negedge clk);
    opValid = v; condPass = c; isWrite = w; targetSaved = s;
    flagsOnly = f; useImm = im; regIdx = r; regData = d; immField = imf;
    fire = v && c;
    inv  = fire && (r == 4'd15) && !(w && im);
    b    = bankOf(mCur[4:0]);
    dbl  = {32'd0, 24'd0, imf[7:0]} | ({32'd0, 24'd0, imf[7:0]} << 32);
    dbl  = dbl >> (2 * imf[11:8]);
    rot  = dbl[31:0];
    src  = im ? rot : d;
    flagsEff = f || im;
    it.req = req;
    it.expInv = inv;
    it.expRd = 32'd0;
    if (fire && !inv && !w)
      it.expRd = s ? ((b >= 0) ? mSaved[b] : 32'd0) : mCur;
    if (fire && !inv && w) begin
      if (s) begin
        if (b >= 0) mSaved[b] = flagsEff ? {src[31:28], mSaved[b][27:0]} : src;
      end else begin
        mCur = (flagsEff || mCur[4:0] == 5'b10000) ? {src[31:28], mCur[27:0]} : src;
      end
    end
    it.expCur = mCur;
    sbq.push_back(it);
  endtask

  task automatic rdOp(input string req, input logic s);
    doOp(req, 1, 1, 0, s, 0, 0, 4'd2, 32'd0, 12'd0);
  endtask

  // monitor: one quarter period after the edge that commits the operation (R11)
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        chk(it.req, "rdData", rdData, it.expRd);
        chk(it.req, "opInvalid", {31'd0, opInvalid}, {31'd0, it.expInv});
        chk(it.req, "curPsr", curPsr, it.expCur);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    mCur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) mSaved[i] = 32'd0;
    #(CLK_PERIOD*2 + 2);
    chk("R1", "reset curPsr", curPsr, 32'h0000_00D3);
    chk("R10", "idle rdData", rdData, 32'd0);
    rstN = 1'b1;
    // R1 saved word of supervisor is zero after reset
    rdOp("R1", 1);
    // R7 read of current word
    rdOp("R7", 0);
    // R6 full-word write to supervisor saved word, then R7 readback
    doOp("R6", 1, 1, 1, 1, 0, 0, 4'd3, 32'h1234_5678, 12'd0);
    rdOp("R7", 1);
    // R6 flags-only write to saved word
    doOp("R6", 1, 1, 1, 1, 1, 0, 4'd3, 32'hE000_0000, 12'd0);
    rdOp("R6", 1);
    // R2 flags-only write to current word from register
    doOp("R2", 1, 1, 1, 0, 1, 0, 4'd4, 32'hA5FF_FFFF, 12'd0);
    // R3 immediate 0x5A rotated right by 4 -> 0xA0000005, flags 0xA
    doOp("R3", 1, 1, 1, 0, 1, 1, 4'd15, 32'hFFFF_FFFF, 12'h25A);
    // R3 immediate without flags-only select: 0xC3 ror 8 -> 0xC3000000, still flags only
    doOp("R3", 1, 1, 1, 0, 0, 1, 4'd0, 32'd0, 12'h4C3);
    // R3 rotate amount zero: 0x0F -> flags cleared
    doOp("R3", 1, 1, 1, 0, 1, 1, 4'd0, 32'd0, 12'h00F);
    // R10 condition failed, then no operation presented
    doOp("R10", 1, 0, 1, 0, 0, 0, 4'd1, 32'hFFFF_FFFF, 12'd0);
    doOp("R10", 0, 1, 1, 0, 0, 0, 4'd1, 32'hFFFF_FFFF, 12'd0);
    doOp("R10", 1, 0, 0, 0, 0, 0, 4'd1, 32'd0, 12'd0);
    // R9 register 15 read and write
    doOp("R9", 1, 1, 0, 0, 0, 0, 4'd15, 32'd0, 12'd0);
    doOp("R9", 1, 1, 1, 0, 0, 0, 4'd15, 32'h0000_0010, 12'd0);
    doOp("R9", 1, 1, 1, 1, 0, 0, 4'd15, 32'hFFFF_FFFF, 12'd0);
    // R5 privileged full write: move to interrupt mode
    doOp("R5", 1, 1, 1, 0, 0, 0, 4'd1, 32'h3000_0092, 12'd0);
    // R6 interrupt mode has its own saved word
    rdOp("R6", 1);
    doOp("R6", 1, 1, 1, 1, 0, 0, 4'd1, 32'hDEAD_BEEF, 12'd0);
    rdOp("R7", 1);
    doOp("R5", 1, 1, 1, 0, 0, 0, 4'd1, 32'h0000_00D3, 12'd0);
    rdOp("R6", 1);
    // R8 system mode: saved access ignored
    doOp("R5", 1, 1, 1, 0, 0, 0, 4'd1, 32'h9000_001F, 12'd0);
    doOp("R8", 1, 1, 1, 1, 0, 0, 4'd1, 32'h5555_5555, 12'd0);
    rdOp("R8", 1);
    doOp("R5", 1, 1, 1, 0, 0, 0, 4'd1, 32'h0000_00D3, 12'd0);
    rdOp("R8", 1);
    // R4 user mode: full writes only reach the flags
    doOp("R5", 1, 1, 1, 0, 0, 0, 4'd1, 32'h0000_0010, 12'd0);
    doOp("R4", 1, 1, 1, 0, 0, 0, 4'd1, 32'hF000_00DF, 12'd0);
    doOp("R4", 1, 1, 1, 0, 0, 0, 4'd1, 32'h6FFF_FF13, 12'd0);
    doOp("R8", 1, 1, 1, 1, 0, 0, 4'd1, 32'h1111_1111, 12'd0);
    rdOp("R8", 1);
    rdOp("R7", 0);
    doOp("R10", 0, 0, 0, 0, 0, 0, 4'd0, 32'd0, 12'd0);
    wait (sbq.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end
endmodule